// File: doc/BRIEF.md
# Frame-Synchronised Byte Serial Port

This block moves bytes between a pair of small FIFOs and a four-wire synchronous serial link. The link has one serial clock, one frame-sync line, an outgoing data pin and an incoming data pin. Bytes travel MSB first and follow each other with no spare clocks between them. A one-clock frame-sync pulse marks every byte boundary. The pulse falls in the clock that carries bit 0 of the byte before, so the next MSB follows directly.

In master mode the port makes the serial clock from the system clock with a programmable divider. That clock runs without a break while the port is enabled, and the port also generates the frame sync. In slave mode, clock and frame sync come from the pins. They are resynchronised to the system clock, and the external clock may rest low between bursts.

Software-side logic pushes bytes for transmission, pops received bytes and watches two sticky flags. An RX overrun flag is cleared by a dedicated strobe. A TX underflow flag clears itself on the next write of transmit data. When a byte is due and no transmit data is waiting, the port sends a byte of zeros.

Top module: `fsync_serial_port`

## Requirements
- R1: Bytes written with `tx_wr` leave the port in write order, and bytes received are read back in arrival order from `rx_rdata` (the head of the RX FIFO, removed by `rx_rd`). Each FIFO holds `FIFO_DEPTH` bytes.
- R2: Each byte is shifted MSB first. Outgoing bits change after a rising serial-clock edge. Incoming bits are captured on the falling serial-clock edge.
- R3: Frame sync is high for exactly one serial-clock period, in the period that carries bit 0 of the previous byte (or one idle period before a first byte). The MSB of the new byte is driven in the very next period, and back-to-back bytes need no extra clocks. In master mode, `fs_out` pulses once every `DATA_W` serial clocks.
- R4: In master mode with `enable` high, `sclk_out` toggles every `HALF_DIV` system clocks whether or not data is waiting. With `enable` low it stays low.
- R5: In slave mode, the serial clock and frame sync come from `sclk_in` and `fs_in`, and `sclk_out` and `fs_out` stay low. `tx_oe` is low whenever no byte is being shifted out. It drops at the first rising edge after a byte's bit 0 that is not preceded by a frame sync, and it drops whenever `enable` is low.
- R6: When a byte starts and the TX FIFO is empty, the byte sent is all zeros and `udr_flag` is set. The flag stays set until R7 applies.
- R7: Any `tx_wr` clears `udr_flag`, unless an underflow happens in the same cycle.
- R8: A byte that completes while the RX FIFO is full is discarded, the FIFO contents are unchanged, and `ovr_flag` is set.
- R9: `ovr_flag` stays set until `ovr_clr` is pulsed. A new overrun in the same cycle wins over the clear.
- R10: After reset, both FIFOs are empty, both flags are clear, and `tx_oe`, `sclk_out` and `fs_out` are low.
- R11: A `tx_wr` while the TX FIFO is full is ignored, and the byte is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the serial engine (and the clock, in master mode) |
| master | input | 1 | 1 = port drives clock and frame sync, 0 = follows the pins |
| tx_wr | input | 1 | Push `tx_wdata` into the TX FIFO |
| tx_wdata | input | DATA_W | Byte to transmit |
| tx_full | output | 1 | TX FIFO full |
| tx_empty | output | 1 | TX FIFO empty |
| rx_rd | input | 1 | Pop the RX FIFO head |
| rx_rdata | output | DATA_W | RX FIFO head |
| rx_empty | output | 1 | RX FIFO empty |
| ovr_clr | input | 1 | Clears the overrun flag |
| ovr_flag | output | 1 | Sticky RX overrun |
| udr_flag | output | 1 | Sticky TX underflow |
| sclk_in | input | 1 | Serial clock from the remote master |
| fs_in | input | 1 | Frame sync from the remote master |
| rx_in | input | 1 | Incoming serial data |
| sclk_out | output | 1 | Generated serial clock (master mode) |
| fs_out | output | 1 | Generated frame sync (master mode) |
| tx_out | output | 1 | Outgoing serial data |
| tx_oe | output | 1 | Drive enable for the data pin; low means tristate |

## Verification
The bench builds the port with `FIFO_DEPTH` = 4, `HALF_DIV` = 4 and `DATA_W` = 8. The shallow FIFOs let a handful of writes reach a full TX FIFO, and let a few unread frames overflow the RX FIFO. The short divider keeps each master frame at 64 system clocks, so many frames fit into a short run. In master mode the bench wires `tx_out` back to `rx_in`, so both shift paths are checked against each other. In slave mode the bench plays the remote master. It sends a gated burst of three back-to-back bytes with the clock resting low on either side, and the third byte is not backed by transmit data.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef int unsigned fsp_uint_t;

  // Modulo step of a pointer or counter that wraps at lim.
  function automatic fsp_uint_t fsp_step(input fsp_uint_t v, input fsp_uint_t lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // Master frame-sync decision: pulse in the period after the counter hits the last slot.
  function automatic logic fsp_fs_due(input fsp_uint_t slot, input fsp_uint_t width);
    return slot == width - 1;
  endfunction
endpackage

// File: rtl/fsp_fifo.sv
module fsp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  import fsp_pkg::*;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= AW'(fsp_step(fsp_uint_t'(wp), DEPTH));
      if (do_pop)  rp <= AW'(fsp_step(fsp_uint_t'(rp), DEPTH));
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/fsp_sclk.sv
module fsp_sclk #(
  parameter int W        = 8,
  parameter int HALF_DIV = 4,
  parameter int SYNC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic master,
  input  logic sclk_in,
  input  logic fs_in,
  input  logic rx_in,
  output logic sclk_out,
  output logic fs_out,
  output logic sck_rise,
  output logic sck_fall,
  output logic fs_src,
  output logic rx_bit
);
  import fsp_pkg::*;
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int FW = (W > 1) ? $clog2(W) : 1;

  logic [SYNC-1:0] s_sck, s_fs, s_rx;
  logic [DW-1:0]   div;
  logic [FW-1:0]   slot;
  logic            sck_m, fs_m, sck_d, sck_src, m_on;

  assign m_on = enable & master;

  // Pin resynchronisers (same depth keeps clock, sync and data aligned)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sck <= '0;
      s_fs  <= '0;
      s_rx  <= '0;
    end else begin
      s_sck <= {s_sck[SYNC-2:0], sclk_in};
      s_fs  <= {s_fs[SYNC-2:0], fs_in};
      s_rx  <= {s_rx[SYNC-2:0], rx_in};
    end
  end

  // Master clock divider and frame-sync slot counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div   <= '0;
      sck_m <= 1'b0;
      fs_m  <= 1'b0;
      slot  <= FW'(W - 2);
    end else if (!m_on) begin
      div   <= '0;
      sck_m <= 1'b0;
      fs_m  <= 1'b0;
      slot  <= FW'(W - 2);
    end else if (div == DW'(HALF_DIV - 1)) begin
      div   <= '0;
      sck_m <= ~sck_m;
      if (!sck_m) begin
        fs_m <= fsp_fs_due(fsp_uint_t'(slot), W);
        slot <= FW'(fsp_step(fsp_uint_t'(slot), W));
      end
    end else begin
      div <= div + 1'b1;
    end
  end

  assign sck_src = master ? sck_m : s_sck[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_src;
  end

  assign sck_rise = sck_src & ~sck_d;
  assign sck_fall = ~sck_src & sck_d;
  assign fs_src   = master ? fs_m : s_fs[SYNC-1];
  assign rx_bit   = s_rx[SYNC-1];
  assign sclk_out = sck_m;
  assign fs_out   = fs_m;
endmodule

// File: rtl/fsp_engine.sv
module fsp_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         fs_src,
  input  logic         rx_bit,
  input  logic         tx_empty,
  input  logic [W-1:0] tx_head,
  output logic         tx_load,
  output logic         tx_pop,
  output logic         udr_evt,
  output logic         rx_push,
  output logic [W-1:0] rx_byte,
  output logic         tx_out,
  output logic         tx_oe
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;

  logic          fs_hit, toe, ract;
  logic [W-1:0]  tsr, rsr;
  logic [BW-1:0] tleft, rcnt;

  assign tx_load = enable & sck_rise & fs_hit;
  assign tx_pop  = tx_load & ~tx_empty;
  assign udr_evt = tx_load & tx_empty;
  assign rx_byte = {rsr[W-2:0], rx_bit};
  assign rx_push = enable & sck_fall & ~fs_hit & ract & (rcnt == BW'(W - 1));
  assign tx_out  = toe & tsr[W-1];
  assign tx_oe   = toe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_hit <= 1'b0; toe <= 1'b0; ract <= 1'b0;
      tsr <= '0; rsr <= '0; tleft <= '0; rcnt <= '0;
    end else if (!enable) begin
      fs_hit <= 1'b0; toe <= 1'b0; ract <= 1'b0;
      tsr <= '0; rsr <= '0; tleft <= '0; rcnt <= '0;
    end else begin
      // falling edge: capture data, then the frame-sync level
      if (sck_fall) begin
        fs_hit <= fs_src;
        if (fs_hit) begin
          rsr  <= W'(rx_bit);
          rcnt <= BW'(1);
          ract <= 1'b1;
        end else if (ract) begin
          rsr <= rx_byte;
          if (rcnt == BW'(W - 1)) begin
            ract <= 1'b0;
            rcnt <= '0;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
      end
      // rising edge: start a byte after a sync, otherwise shift or release the pin
      if (sck_rise) begin
        if (fs_hit) begin
          tsr   <= tx_empty ? '0 : tx_head;
          toe   <= 1'b1;
          tleft <= BW'(W - 1);
        end else if (toe) begin
          if (tleft == '0) begin
            toe <= 1'b0;
          end else begin
            tsr   <= {tsr[W-2:0], 1'b0};
            tleft <= tleft - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fsync_serial_port.sv
module fsync_serial_port #(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 16,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              master,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_rdata,
  output logic              rx_empty,
  input  logic              ovr_clr,
  output logic              ovr_flag,
  output logic              udr_flag,
  input  logic              sclk_in,
  input  logic              fs_in,
  input  logic              rx_in,
  output logic              sclk_out,
  output logic              fs_out,
  output logic              tx_out,
  output logic              tx_oe
);
  logic              sck_rise, sck_fall, fs_src, rx_bit;
  logic              tx_load, tx_pop, udr_evt, rx_push, rx_full, rx_drop;
  logic [DATA_W-1:0] tx_head, rx_byte;

  fsp_sclk #(.W(DATA_W), .HALF_DIV(HALF_DIV), .SYNC(SYNC_STAGES)) u_sclk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .master(master),
    .sclk_in(sclk_in), .fs_in(fs_in), .rx_in(rx_in),
    .sclk_out(sclk_out), .fs_out(fs_out), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .fs_src(fs_src), .rx_bit(rx_bit));

  fsp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_wr), .wdata(tx_wdata), .pop(tx_pop),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty));

  fsp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte), .pop(rx_rd),
    .rdata(rx_rdata), .full(rx_full), .empty(rx_empty));

  fsp_engine #(.W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .fs_src(fs_src), .rx_bit(rx_bit), .tx_empty(tx_empty), .tx_head(tx_head),
    .tx_load(tx_load), .tx_pop(tx_pop), .udr_evt(udr_evt), .rx_push(rx_push),
    .rx_byte(rx_byte), .tx_out(tx_out), .tx_oe(tx_oe));

  assign rx_drop = rx_push & rx_full;

  // Sticky flags: a new event wins over its clearing action
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      udr_flag <= 1'b0;
    end else begin
      if (rx_drop)      ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
      if (udr_evt)      udr_flag <= 1'b1;
      else if (tx_wr)   udr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/fsp_chk.sv
module fsp_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         tx_wr,
  input logic         rx_rd,
  input logic         ovr_clr,
  input logic         ovr_flag,
  input logic         udr_flag,
  input logic         tx_out,
  input logic         tx_oe,
  input logic         sclk_out,
  input logic         tx_load,
  input logic         udr_evt,
  input logic         rx_push,
  input logic         rx_full,
  input logic [W-1:0] rx_rdata
);
  AST_LOAD_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_oe); // R3
  AST_CLOCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sclk_out); // R4
  AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tx_oe); // R5
  AST_UDR_ZERO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    udr_evt |=> (tx_oe && !tx_out)); // R6
  AST_UDR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    udr_evt |=> udr_flag); // R6
  AST_UDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !udr_evt) |=> !udr_flag); // R7
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> ovr_flag); // R8
  AST_OVR_HEAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !rx_rd) |=> $stable(rx_rdata)); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag); // R9
endmodule

bind fsync_serial_port fsp_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tx_wr(tx_wr), .rx_rd(rx_rd),
  .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .udr_flag(udr_flag), .tx_out(tx_out),
  .tx_oe(tx_oe), .sclk_out(sclk_out), .tx_load(tx_load), .udr_evt(udr_evt),
  .rx_push(rx_push), .rx_full(rx_full), .rx_rdata(rx_rdata));

// File: tb/sim_fsync_serial_port.sv
module sim_fsync_serial_port;
  localparam int W = 8, DEPTH = 4, HDIV = 4, SYNC = 2;
  localparam int SHALF = 8; // bench master half period, in system clocks

  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic rst_n, enable, master, tx_wr, rx_rd, ovr_clr, sclk_in, fs_in, rx_in;
  logic [W-1:0] tx_wdata, rx_rdata;
  logic tx_full, tx_empty, rx_empty, ovr_flag, udr_flag, sclk_out, fs_out, tx_out, tx_oe;
  logic loop_en, rx_drv, mon_on, drain_on, done;

  assign rx_in = loop_en ? tx_out : rx_drv;

  fsync_serial_port #(.DATA_W(W), .FIFO_DEPTH(DEPTH), .HALF_DIV(HDIV), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .master(master), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .tx_full(tx_full), .tx_empty(tx_empty), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .rx_empty(rx_empty), .ovr_clr(ovr_clr), .ovr_flag(ovr_flag),
    .udr_flag(udr_flag), .sclk_in(sclk_in), .fs_in(fs_in), .rx_in(rx_in),
    .sclk_out(sclk_out), .fs_out(fs_out), .tx_out(tx_out), .tx_oe(tx_oe));

  int n_chk = 0, n_bad = 0, n_drained = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] tx_exp [3];
  logic [W-1:0] rx_pat [3];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // Driver: write a TX byte; optionally queue it as an expected received byte
  task automatic push_tx(input logic [W-1:0] b, input bit expect_rx);
    @(negedge clk);
    tx_wr = 1'b1; tx_wdata = b;
    @(negedge clk);
    tx_wr = 1'b0;
    if (expect_rx) exp_q.push_back(b);
  endtask

  task automatic check_fs_period(input string req);
    int n = 0;
    @(posedge fs_out); #1;
    do begin
      @(posedge sclk_out); #1;
      n++;
    end while (!fs_out && n < 40);
    chk(n == W, req, n, W);
  endtask

  // Bench as remote master: 3 back-to-back bytes, one trailing clock, clock low around it
  task automatic slave_burst();
    logic [W-1:0] acc = '0;
    for (int c = 0; c < 26; c++) begin
      @(negedge clk);
      sclk_in = 1'b1;
      fs_in   = (c == 0 || c == 8 || c == 16);
      rx_drv  = (c >= 1 && c <= 24) ? rx_pat[(c-1)/8][7-((c-1)%8)] : 1'b0;
      repeat (SHALF) @(negedge clk);
      sclk_in = 1'b0;
      if (c >= 1 && c <= 24) begin
        acc = {acc[W-2:0], tx_out};
        if (c == 1) chk(tx_oe == 1'b1, "R3", tx_oe, 1);
        if ((c % 8) == 0)
          chk(acc == tx_exp[c/8-1], (c == 24) ? "R6" : "R2", acc, tx_exp[c/8-1]);
      end
      repeat (SHALF - 1) @(negedge clk);
    end
    fs_in = 1'b0; rx_drv = 1'b0;
  endtask

  // Monitor: pops the RX FIFO and scores non-zero bytes against the queue
  initial begin
    rx_rd = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && (mon_on || drain_on) && !rx_empty) begin
        if (drain_on) n_drained++;
        else if (rx_rdata != '0) begin
          if (exp_q.size() == 0) chk(1'b0, "R1", rx_rdata, 0);
          else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            chk(rx_rdata == e, "R1", rx_rdata, e);
          end
        end
        rx_rd = 1'b1;
      end else begin
        rx_rd = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    done = 1'b0; rst_n = 1'b0; enable = 1'b0; master = 1'b0; tx_wr = 1'b0; tx_wdata = '0;
    ovr_clr = 1'b0; sclk_in = 1'b0; fs_in = 1'b0; rx_drv = 1'b0; loop_en = 1'b0;
    mon_on = 1'b0; drain_on = 1'b0;
    tx_exp[0] = 8'hB7; tx_exp[1] = 8'h4D; tx_exp[2] = 8'h00;
    rx_pat[0] = 8'h96; rx_pat[1] = 8'h2B; rx_pat[2] = 8'hE1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(tx_empty && rx_empty && !tx_full, "R10", {tx_empty, rx_empty, tx_full}, 3'b110);
    chk(!ovr_flag && !udr_flag, "R10", {ovr_flag, udr_flag}, 0);
    chk(!tx_oe && !sclk_out && !fs_out, "R10", {tx_oe, sclk_out, fs_out}, 0);

    // R11: fill TX, one more write is dropped
    push_tx(8'h5A, 1); push_tx(8'hC3, 1); push_tx(8'h81, 1); push_tx(8'h3F, 1);
    chk(tx_full, "R11", tx_full, 1);
    push_tx(8'hE7, 0);

    // Master loopback (R1, R3, R4, R6, R7)
    @(negedge clk);
    loop_en = 1'b1; master = 1'b1; mon_on = 1'b1; enable = 1'b1;
    check_fs_period("R3");
    check_fs_period("R3");
    repeat (3) @(posedge fs_out);
    @(negedge clk);
    chk(udr_flag, "R6", udr_flag, 1);
    check_fs_period("R4");
    @(negedge clk);
    chk(udr_flag, "R6", udr_flag, 1);
    chk(!ovr_flag, "R8", ovr_flag, 0);
    @(posedge fs_out);
    push_tx(8'h6B, 1);
    chk(!udr_flag, "R7", udr_flag, 0);
    repeat (3) @(posedge fs_out);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R1", exp_q.size(), 0);

    // Overrun (R8, R9)
    mon_on = 1'b0;
    repeat (DEPTH + 3) @(posedge fs_out);
    @(negedge clk);
    chk(ovr_flag, "R8", ovr_flag, 1);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    begin
      int hi = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (sclk_out) hi++;
      end
      chk(hi == 0, "R4", hi, 0);
    end
    chk(ovr_flag, "R9", ovr_flag, 1);
    drain_on = 1'b1;
    repeat (2 * DEPTH + 4) @(negedge clk);
    drain_on = 1'b0;
    @(negedge clk);
    chk(n_drained == DEPTH, "R8", n_drained, DEPTH);
    chk(ovr_flag, "R9", ovr_flag, 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(!ovr_flag, "R9", ovr_flag, 0);

    // Slave burst (R2, R3, R5, R6, R7)
    master = 1'b0; loop_en = 1'b0;
    @(negedge clk);
    push_tx(8'hB7, 0); push_tx(8'h4D, 0);
    chk(!udr_flag, "R7", udr_flag, 0);
    exp_q.push_back(8'h96); exp_q.push_back(8'h2B); exp_q.push_back(8'hE1);
    mon_on = 1'b1; enable = 1'b1;
    repeat (10) @(negedge clk);
    chk(!tx_oe && !sclk_out && !fs_out, "R5", {tx_oe, sclk_out, fs_out}, 0);
    slave_burst();
    repeat (20) @(negedge clk);
    chk(!tx_oe, "R5", tx_oe, 0);
    chk(udr_flag, "R6", udr_flag, 1);
    chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
    finish_run();
  end
endmodule